// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns one PWM command into the two switch enables of a synchronous buck half-bridge, the high-side and the low-side. It never lets both be active together. Each turn-on waits for a digital "that switch is now off" flag from an external comparator, then waits a short, fixed number of clocks. Turn-offs take effect as soon as the PWM change is seen.

On a falling PWM edge the low side normally waits for the switch node to fall. If the converter is sinking current, the switch node may never fall. For that case a longer fallback timer starts when the high-side gate is seen discharged, and it turns the low side on when it expires. This makes sure the bootstrap supply is refreshed in every cycle. An active-low disable input forces both enables low at once. Every flag, the PWM bit and the disable input pass through a synchronizer before the state machine samples them.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: `hs_en_o` and `ls_en_o` are never high in the same cycle.
- R2: While `out_dis_ni` is low, both enables are low. This takes effect in the same cycle, without waiting for a clock edge.
- R3: While enabled and after the handshake has completed, `hs_en_o` equals PWM and `ls_en_o` equals its inverse.
- R4: After PWM rises, `ls_en_o` drops on the 3rd rising clock edge. `hs_en_o` stays low until `ls_gate_low_i` is high. It then rises on the (PRI_DLY+2)th rising edge after that flag is applied, provided the flag stays high.
- R5: After PWM falls, `hs_en_o` drops on the 3rd rising edge. `ls_en_o` stays low until `sw_low_i` is high. It then rises on the (PRI_DLY+2)th rising edge after that flag is applied.
- R6: After PWM falls, a high `hs_gs_low_i` starts a fallback timer that keeps running once started. Even if `sw_low_i` stays low, `ls_en_o` rises on the (SEC_DLY+2)th rising edge after the flag is applied. Elaboration fails unless SEC_DLY > PRI_DLY >= 1.
- R7: If PWM reverses before a pending turn-on completes, that turn-on and its timers are cancelled. The opposite transition then starts from the both-off state, with its timers counting from zero.
- R8: During reset, and after the disable is released, both enables are low. Normal operation resumes only through the sensed-off handshake for the current PWM level. With the flag already present, the turn-on comes on the (PRI_DLY+3)th edge after release.
- R9: With the default delays and a 100 MHz clock, a 500 kHz PWM with a responsive plant produces one high-side and one low-side turn-on in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command; high requests the high-side switch |
| out_dis_ni | input | 1 | Output disable, active low |
| ls_gate_low_i | input | 1 | Low-side gate is discharged |
| sw_low_i | input | 1 | Switch node is below its threshold |
| hs_gs_low_i | input | 1 | High-side gate-source voltage is discharged |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |

## Verification
The properties assume that any low pulse on `out_dis_ni` lasts at least one full clock period, so the synchronized copy always registers it. They also assume that the sense flags change only between clock edges. The bench drives every input on the falling clock edge and holds each disable for tens of cycles. In the periodic run, a plant model derives each flag from the enables, so the flags remain consistent with the switch states. Turn-on latency is measured from the cycle in which a flag is applied, counting the synchronizer stages.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_HI,
    ST_HI_ON,
    ST_WAIT_LO,
    ST_LO_ON
  } gdc_state_e;
endpackage

// File: rtl/gdc_sync.sv
module gdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gdc_timer.sv
// Qualified delay: done fires in the DLY-th cycle that the trigger is seen.
module gdc_timer #(
  parameter int DLY   = 3,
  parameter bit LATCH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  output logic done_o
);
  localparam int W = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [W-1:0] LAST = W'(DLY - 1);

  logic [W-1:0] cnt_q;
  logic         run;

  if (LATCH) begin : g_latch
    // once started, keep counting even if the trigger drops
    assign run = trig_i | (cnt_q != '0);
  end else begin : g_level
    assign run = trig_i;
  end

  assign done_o = !clr_i && run && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || done_o || !run) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gdc_fsm.sv
module gdc_fsm
  import gdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_s_i,
  input  logic       pwm_s_i,
  input  logic       hi_go_i,
  input  logic       lo_go_i,
  output gdc_state_e state_o,
  output logic       hs_q_o,
  output logic       ls_q_o
);
  gdc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     state_d = pwm_s_i ? ST_WAIT_HI : ST_WAIT_LO;
      ST_WAIT_HI: if (!pwm_s_i) state_d = ST_WAIT_LO;
                  else if (hi_go_i) state_d = ST_HI_ON;
      ST_HI_ON:   if (!pwm_s_i) state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (pwm_s_i) state_d = ST_WAIT_HI;
                  else if (lo_go_i) state_d = ST_LO_ON;
      ST_LO_ON:   if (pwm_s_i) state_d = ST_WAIT_HI;
      default:    state_d = ST_OFF;
    endcase
    if (!en_s_i) state_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else state_q <= state_d;
  end

  assign state_o = state_q;
  assign hs_q_o  = (state_q == ST_HI_ON);
  assign ls_q_o  = (state_q == ST_LO_ON);
endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
  import gdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRI_DLY     = 3,
  parameter int SEC_DLY     = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic out_dis_ni,
  input  logic ls_gate_low_i,
  input  logic sw_low_i,
  input  logic hs_gs_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int SYNC_W = 5;

  if (PRI_DLY < 1 || SEC_DLY <= PRI_DLY) begin : g_bad_cfg
    $error("gate_deadtime_ctrl: need SEC_DLY > PRI_DLY >= 1");
  end

  logic [SYNC_W-1:0] raw_in, syn_out;
  logic en_s, pwm_s, ls_low_s, sw_low_s, hs_low_s;
  logic hi_go, lo_pri_go, lo_sec_go;
  logic hs_q, ls_q;
  gdc_state_e state;

  assign raw_in = {out_dis_ni, pwm_i, ls_gate_low_i, sw_low_i, hs_gs_low_i};
  assign {en_s, pwm_s, ls_low_s, sw_low_s, hs_low_s} = syn_out;

  gdc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(syn_out)
  );

  gdc_timer #(.DLY(PRI_DLY), .LATCH(1'b0)) u_tmr_hi (
    .clk_i, .rst_ni, .clr_i(state != ST_WAIT_HI), .trig_i(ls_low_s), .done_o(hi_go)
  );

  gdc_timer #(.DLY(PRI_DLY), .LATCH(1'b0)) u_tmr_lo_pri (
    .clk_i, .rst_ni, .clr_i(state != ST_WAIT_LO), .trig_i(sw_low_s), .done_o(lo_pri_go)
  );

  gdc_timer #(.DLY(SEC_DLY), .LATCH(1'b1)) u_tmr_lo_sec (
    .clk_i, .rst_ni, .clr_i(state != ST_WAIT_LO), .trig_i(hs_low_s), .done_o(lo_sec_go)
  );

  gdc_fsm u_fsm (
    .clk_i, .rst_ni, .en_s_i(en_s), .pwm_s_i(pwm_s),
    .hi_go_i(hi_go), .lo_go_i(lo_pri_go | lo_sec_go),
    .state_o(state), .hs_q_o(hs_q), .ls_q_o(ls_q)
  );

  // raw disable gates the outputs without waiting for the synchronizer
  assign hs_en_o = hs_q & out_dis_ni;
  assign ls_en_o = ls_q & out_dis_ni;
endmodule

// File: rtl/gdc_checker.sv
module gdc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s,
  input logic pwm_s,
  input logic ls_low_s,
  input logic hs_q,
  input logic ls_q,
  input logic hs_en_o,
  input logic ls_en_o
);
  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  assert_no_overlap_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hs_q, ls_q}));

  assert_disable_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> (!hs_q && !ls_q));

  assert_hi_after_ls_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(ls_low_s && pwm_s));

  assert_ls_drop_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_s) |=> !ls_q);

  assert_hs_drop_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_s) |=> !hs_q);

  assert_lo_needs_low_pwm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> $past(!pwm_s));
endmodule

bind gate_deadtime_ctrl gdc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_s(en_s), .pwm_s(pwm_s), .ls_low_s(ls_low_s),
  .hs_q(hs_q), .ls_q(ls_q), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
);

// File: tb/tb_gate_deadtime_ctrl.sv
module tb_gate_deadtime_ctrl;
  localparam int PRI = 3;
  localparam int SEC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b1, dis_n = 1'b1, lsl = 1'b1, swl = 1'b1, hsl = 1'b1;
  logic plant = 1'b0;
  logic ls_gate_low, sw_low, hs_gs_low, hs_en, ls_en;
  int total = 0, bad = 0, overlap = 0;

  always #5 clk = ~clk;

  // plant model: flags follow the enables when enabled
  assign ls_gate_low = plant ? !ls_en : lsl;
  assign sw_low      = plant ? !hs_en : swl;
  assign hs_gs_low   = plant ? !hs_en : hsl;

  gate_deadtime_ctrl #(.PRI_DLY(PRI), .SEC_DLY(SEC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .out_dis_ni(dis_n),
    .ls_gate_low_i(ls_gate_low), .sw_low_i(sw_low), .hs_gs_low_i(hs_gs_low),
    .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  // R1 monitor
  always @(negedge clk) if (rst_n && hs_en && ls_en) overlap++;

  typedef struct packed {
    logic p, d, l, s, h;
    logic [7:0] n;
    logic eh, el;
    logic [3:0] req;
  } vec_t;

  // pwm, dis_n, ls_low, sw_low, hs_low, cycles, exp hs, exp ls, requirement
  localparam vec_t VECS [11] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40, 1'b0, 1'b1, 4'd3}, // R3 low side follows
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40, 1'b1, 1'b0, 4'd3}, // R3 high side follows
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd40, 1'b1, 1'b0, 4'd3}, // R3 flags ignored when on
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd40, 1'b0, 1'b0, 4'd5}, // R5 waits for switch node
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd40, 1'b0, 1'b1, 4'd6}, // R6 fallback turn-on
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd40, 1'b0, 1'b0, 4'd4}, // R4 waits for ls gate low
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40, 1'b1, 1'b0, 4'd4}, // R4 turn-on
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd40, 1'b0, 1'b0, 4'd2}, // R2 disabled
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40, 1'b1, 1'b0, 4'd8}, // R8 re-enable
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd40, 1'b0, 1'b0, 4'd2}, // R2 disabled, pwm low
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40, 1'b0, 1'b1, 4'd8}  // R8 re-enable, pwm low
  };

  task automatic drive(input logic p, d, l, s, h);
    pwm = p; dis_n = d; lsl = l; swl = s; hsl = h;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic eh, el);
    total++;
    if (hs_en !== eh || ls_en !== el) begin
      bad++;
      $display("FAIL %s: hs/ls=%b%b expected %b%b at %0t", req, hs_en, ls_en, eh, el, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R8 reset state
    cyc(3);
    chk("R8 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R8 after reset", 1'b0, 1'b0);

    for (int i = 0; i < 11; i++) begin
      drive(VECS[i].p, VECS[i].d, VECS[i].l, VECS[i].s, VECS[i].h);
      cyc(int'(VECS[i].n));
      total++;
      if (hs_en !== VECS[i].eh || ls_en !== VECS[i].el) begin
        bad++;
        $display("FAIL R%0d vec %0d: hs/ls=%b%b expected %b%b",
                 VECS[i].req, i, hs_en, ls_en, VECS[i].eh, VECS[i].el);
      end
    end

    // R4: low side drops first, high side waits for flag, exact delay
    drive(1, 1, 0, 1, 1);
    cyc(2);  chk("R4 ls held before 3rd edge", 1'b0, 1'b1);
    cyc(1);  chk("R4 ls dropped", 1'b0, 1'b0);
    cyc(20); chk("R4 hs waits", 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1);
    cyc(PRI + 1); chk("R4 hs not early", 1'b0, 0);
    cyc(1);       chk("R4 hs exact", 1'b1, 1'b0);

    // R5: high side drops first, low side waits for switch node
    drive(0, 1, 1, 0, 0);
    cyc(2);  chk("R5 hs held before 3rd edge", 1'b1, 1'b0);
    cyc(1);  chk("R5 hs dropped", 1'b0, 1'b0);
    cyc(30); chk("R5 ls waits", 1'b0, 1'b0);
    drive(0, 1, 1, 1, 0);
    cyc(PRI + 1); chk("R5 ls not early", 1'b0, 1'b0);
    cyc(1);       chk("R5 ls exact", 1'b0, 1'b1);

    // R6: fallback timer with switch node stuck high
    drive(1, 1, 1, 1, 1);
    cyc(40); chk("R6 setup", 1'b1, 1'b0);
    drive(0, 1, 1, 0, 0);
    cyc(20); chk("R6 waiting", 1'b0, 1'b0);
    drive(0, 1, 1, 0, 1);
    cyc(PRI + 1);   chk("R6 not at primary delay", 1'b0, 1'b0);
    cyc(SEC - PRI); chk("R6 not early", 1'b0, 1'b0);
    cyc(1);         chk("R6 fallback exact", 1'b0, 1'b1);

    // R7: reversal cancels pending turn-on and restarts timers
    drive(1, 1, 1, 1, 1);
    cyc(40); chk("R7 setup", 1'b1, 1'b0);
    drive(0, 1, 1, 0, 1);
    cyc(10); chk("R7 pending low side", 1'b0, 1'b0);
    drive(1, 1, 0, 0, 1);
    cyc(5);  chk("R7 reversed, both off", 1'b0, 1'b0);
    drive(0, 1, 1, 0, 1);
    cyc(SEC + 2); chk("R7 timer restarted", 1'b0, 1'b0);
    cyc(1);       chk("R7 fallback after restart", 1'b0, 1'b1);

    // R2 immediate disable, R8 re-entry handshake timing
    drive(1, 1, 1, 1, 1);
    cyc(40); chk("R2 setup", 1'b1, 1'b0);
    drive(1, 0, 1, 1, 1);
    #1;      chk("R2 same-cycle disable", 1'b0, 1'b0);
    cyc(40); chk("R2 held", 1'b0, 1'b0);
    drive(1, 1, 1, 1, 1);
    cyc(PRI + 2); chk("R8 not early", 1'b0, 1'b0);
    cyc(1);       chk("R8 re-enable exact", 1'b1, 1'b0);

    // R9: 500 kHz with a responsive plant
    begin
      int hs_rise = 0, ls_rise = 0;
      logic hs_prev, ls_prev;
      hs_prev = hs_en; ls_prev = ls_en;
      plant = 1'b1;
      for (int i = 0; i < 600; i++) begin
        pwm = ((i % 200) >= 100);
        cyc(1);
        if (hs_en && !hs_prev) hs_rise++;
        if (ls_en && !ls_prev) ls_rise++;
        hs_prev = hs_en; ls_prev = ls_en;
      end
      chk_int("R9 high-side turn-ons", hs_rise, 3);
      chk_int("R9 low-side turn-ons", ls_rise, 3);
    end

    chk_int("R1 overlap cycles", overlap, 0);
    finish_run();
  end
endmodule